// File: doc/BRIEF.md
# Sixteen-Bit ALU with Extension Register

This block is the arithmetic and logic stage of a small 16-bit processor core. Each operation takes a destination operand `b`, a source operand `a` and a 5-bit opcode. From these it returns four things: the value to write back to `b`, a new value for a 16-bit extension register (EX), the two write enables, and a condition flag for the compare-and-skip opcodes. It also reports a cycle cost that the sequencer uses to account for time. Operand fetch, write-back addressing and the skip itself are handled by the surrounding core.

Every arithmetic and shift opcode produces a 32-bit intermediate. Half of it goes to `b` and the other half goes to EX, and which half goes where depends on the opcode. EX is held inside the block. It feeds back into the add-with-carry and subtract-with-carry opcodes, and it loads the new value on the clock edge of an issued operation that writes EX. Results are combinational from the operands, the opcode and the current EX value. All four divide and modulo opcodes share one unsigned restoring divider.

Top module: `alu_ex_unit`

## Requirements
- R1: While reset is applied, and after it is released, the EX register reads 0 until an issued operation writes it.
- R2: For ADD (0x02, b+a), SUB (0x03, b-a), MUL (0x04, unsigned b*a), MLI (0x05, signed b*a), ADX (0x1a, b+a+EX) and SBX (0x1b, b-a+EX), the value is taken modulo 2^32. The low 16 bits go to `b` and the high 16 bits go to EX, and both writes are enabled.
- R3: SHL (0x0f) shifts b left by a inside 32 bits: `b` gets the low half and EX gets the high half. SHR (0x0d) is a logical right shift of (b<<16) by a, and ASR (0x0e) is an arithmetic right shift of the same value. For both, `b` gets the high half and EX gets the low half. A shift count of 32 or more gives all zeros, or sign fill for ASR.
- R4: DIV (0x06) divides (b<<16) by a as unsigned numbers. DVI (0x07) does the same as signed numbers, rounding toward zero. In both cases `b` gets the high half of the quotient and EX gets the low half.
- R5: A divisor of zero writes 0 to `b`. For DIV and DVI it also writes 0 to EX. For MOD and MDI it leaves EX unwritten.
- R6: MOD (0x08) writes the unsigned remainder b%a. MDI (0x09) writes the signed remainder, which takes the sign of b. Neither writes EX.
- R7: AND (0x0a), BOR (0x0b, inclusive or) and XOR (0x0c) write the bitwise result to `b` and leave EX unwritten and unchanged.
- R8: The condition flag is true under these conditions: IFB (0x10) when b&a is nonzero, IFC (0x11) when b&a is zero, IFE (0x12) when b==a, IFN (0x13) when b!=a, IFG (0x14) when b>a unsigned, IFA (0x15) when b>a signed, IFL (0x16) when b<a unsigned, and IFU (0x17) when b<a signed. Compares write neither `b` nor EX. The flag is 0 for every other opcode.
- R9: The cycle cost is as follows: 2 for ADD, SUB, MUL and MLI; 3 for DIV, DVI, MOD, MDI, ADX and SBX; 1 for the bitwise and shift opcodes; 2 for a compare whose condition is true and 3 for one whose condition is false; 1 for an illegal opcode.
- R10: Opcodes 0x00, 0x01, 0x18, 0x19 and 0x1c to 0x1f raise the illegal flag when issued. They enable no write and leave EX unchanged.
- R11: EX loads the new value only on a clock edge where `issue_i` is high and the opcode writes EX. When `issue_i` is low, both write enables and the illegal flag are 0 and EX holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Operation issued this cycle |
| opcode_i | input | 5 | Operation code |
| b_i | input | 16 | Destination operand value |
| a_i | input | 16 | Source operand value |
| result_o | output | 16 | Value to write back to b |
| res_we_o | output | 1 | Write enable for result_o |
| ex_new_o | output | 16 | New EX value (current EX when not written) |
| ex_we_o | output | 1 | EX is written on this cycle's edge |
| ex_o | output | 16 | Current EX register |
| cond_o | output | 1 | Compare condition true |
| illegal_o | output | 1 | Issued opcode is unassigned |
| cost_o | output | 2 | Cycle cost of the operation |

## Verification
On every cycle, the assertions check the following:
- EX loads only on an issued write and holds otherwise.
- Divide by zero yields zeros.
- Illegal opcodes and compares enable no write.
- The packing of the ADD sum.
- The compare cost follows the condition.
- Each divider output satisfies quotient times divisor plus remainder equal to the dividend, with the remainder below the divisor.

Only the bench scenarios can show the opcode-specific values. These cover the carry and borrow patterns in EX, the signed rounding toward zero of DVI and MDI, the large shift counts, and EX carrying from one issued operation into the next ADX or SBX.

// File: rtl/alu_ex_pkg.sv
package alu_ex_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'h02, OP_SUB = 5'h03, OP_MUL = 5'h04, OP_MLI = 5'h05,
    OP_DIV = 5'h06, OP_DVI = 5'h07, OP_MOD = 5'h08, OP_MDI = 5'h09,
    OP_AND = 5'h0a, OP_BOR = 5'h0b, OP_XOR = 5'h0c, OP_SHR = 5'h0d,
    OP_ASR = 5'h0e, OP_SHL = 5'h0f,
    OP_IFB = 5'h10, OP_IFC = 5'h11, OP_IFE = 5'h12, OP_IFN = 5'h13,
    OP_IFG = 5'h14, OP_IFA = 5'h15, OP_IFL = 5'h16, OP_IFU = 5'h17,
    OP_ADX = 5'h1a, OP_SBX = 5'h1b
  } opcode_e;

  function automatic logic is_compare(input logic [OP_W-1:0] op);
    return op[4:3] == 2'b10;
  endfunction

endpackage

// File: rtl/alu_ex_divider.sv
// Unsigned restoring divider, one subtract stage per dividend bit.
module alu_ex_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);

  logic [DEN_W-1:0] part [0:NUM_W];

  assign part[0] = '0;

  for (genvar k = 0; k < NUM_W; k++) begin : g_stage
    logic [DEN_W:0]   shifted;
    logic             take;
    logic [DEN_W-1:0] diff;

    assign shifted = {part[k], num_i[NUM_W-1-k]};
    assign take    = shifted >= {1'b0, den_i};
    assign diff    = shifted[DEN_W-1:0] - den_i;
    assign part[k+1] = take ? diff : shifted[DEN_W-1:0];
    assign quo_o[NUM_W-1-k] = take;
  end

  assign rem_o = part[NUM_W];

endmodule

// File: rtl/alu_ex_addmul.sv
// Add, subtract, multiply and carry-chained forms as one 2W-bit value.
module alu_ex_addmul
  import alu_ex_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e        op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   ex_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o
);

  localparam int DW = 2 * W;

  logic [DW-1:0] b_z, a_z, e_z, b_s, a_s, wide;

  assign b_z = {{W{1'b0}}, b_i};
  assign a_z = {{W{1'b0}}, a_i};
  assign e_z = {{W{1'b0}}, ex_i};
  assign b_s = {{W{b_i[W-1]}}, b_i};
  assign a_s = {{W{a_i[W-1]}}, a_i};

  always_comb begin
    case (op_i)
      OP_ADD:  wide = b_z + a_z;
      OP_SUB:  wide = b_z - a_z;
      OP_MUL:  wide = b_z * a_z;
      OP_MLI:  wide = b_s * a_s;   // low 2W bits of a signed product
      OP_ADX:  wide = b_z + a_z + e_z;
      OP_SBX:  wide = b_z - a_z + e_z;
      default: wide = '0;
    endcase
  end

  assign lo_o = wide[W-1:0];
  assign hi_o = wide[DW-1:W];

endmodule

// File: rtl/alu_ex_shlog.sv
// Shifts, bitwise operations and the compare conditions.
module alu_ex_shlog
  import alu_ex_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e        op_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   a_i,
  output logic [W-1:0]   res_o,
  output logic [W-1:0]   ex_o,
  output logic           cond_o
);

  localparam int DW = 2 * W;

  logic [DW-1:0] left_w, right_w, arith_w;
  logic [W-1:0]  both;

  assign left_w  = {{W{1'b0}}, b_i} << a_i;
  assign right_w = {b_i, {W{1'b0}}} >> a_i;
  assign arith_w = $signed({b_i, {W{1'b0}}}) >>> a_i;
  assign both    = b_i & a_i;

  always_comb begin
    res_o = '0;
    ex_o  = '0;
    case (op_i)
      OP_AND: res_o = both;
      OP_BOR: res_o = b_i | a_i;
      OP_XOR: res_o = b_i ^ a_i;
      OP_SHL: begin res_o = left_w[W-1:0];   ex_o = left_w[DW-1:W];  end
      OP_SHR: begin res_o = right_w[DW-1:W]; ex_o = right_w[W-1:0];  end
      OP_ASR: begin res_o = arith_w[DW-1:W]; ex_o = arith_w[W-1:0];  end
      default: ;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_IFB:  cond_o = |both;
      OP_IFC:  cond_o = ~|both;
      OP_IFE:  cond_o = b_i == a_i;
      OP_IFN:  cond_o = b_i != a_i;
      OP_IFG:  cond_o = b_i > a_i;
      OP_IFA:  cond_o = $signed(b_i) > $signed(a_i);
      OP_IFL:  cond_o = b_i < a_i;
      OP_IFU:  cond_o = $signed(b_i) < $signed(a_i);
      default: cond_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_ex_unit.sv
module alu_ex_unit
  import alu_ex_pkg::*;
#(
  parameter int W      = 16,
  parameter int COST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [W-1:0]      b_i,
  input  logic [W-1:0]      a_i,
  output logic [W-1:0]      result_o,
  output logic              res_we_o,
  output logic [W-1:0]      ex_new_o,
  output logic              ex_we_o,
  output logic [W-1:0]      ex_o,
  output logic              cond_o,
  output logic              illegal_o,
  output logic [COST_W-1:0] cost_o
);

  localparam int DW = 2 * W;
  localparam int PW = DW + W;
  localparam logic [COST_W-1:0] COST1 = COST_W'(1);
  localparam logic [COST_W-1:0] COST2 = COST_W'(2);
  localparam logic [COST_W-1:0] COST3 = COST_W'(3);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  opcode_e  op;
  logic [W-1:0] ex_q;
  assign op = opcode_e'(opcode_i);

  // Arithmetic and shift/logic datapaths.
  logic [W-1:0] am_lo, am_hi, sl_res, sl_ex;
  logic         sl_cond;

  alu_ex_addmul #(.W(W)) addmul_i (
    .op_i(op), .b_i(b_i), .a_i(a_i), .ex_i(ex_q), .lo_o(am_lo), .hi_o(am_hi)
  );

  alu_ex_shlog #(.W(W)) shlog_i (
    .op_i(op), .b_i(b_i), .a_i(a_i), .res_o(sl_res), .ex_o(sl_ex), .cond_o(sl_cond)
  );

  // Shared divider: signed opcodes divide magnitudes and fix the sign after.
  logic         sgn_op, div_op, b_neg, a_neg;
  logic [W-1:0] b_mag, a_mag, dv_rem, rem_fix;
  logic [DW-1:0] dv_num, dv_quo, quo_fix;

  assign sgn_op = (op == OP_DVI) || (op == OP_MDI);
  assign div_op = (op == OP_DIV) || (op == OP_DVI);
  assign b_neg  = sgn_op && b_i[W-1];
  assign a_neg  = sgn_op && a_i[W-1];
  assign b_mag  = b_neg ? (~b_i + 1'b1) : b_i;
  assign a_mag  = a_neg ? (~a_i + 1'b1) : a_i;
  assign dv_num = div_op ? {b_mag, {W{1'b0}}} : {{W{1'b0}}, b_mag};

  alu_ex_divider #(.NUM_W(DW), .DEN_W(W)) divider_i (
    .num_i(dv_num), .den_i(a_mag), .quo_o(dv_quo), .rem_o(dv_rem)
  );

  assign quo_fix = (b_neg ^ a_neg) ? (~dv_quo + 1'b1) : dv_quo;
  assign rem_fix = b_neg ? (~dv_rem + 1'b1) : dv_rem;

  // Result selection and decode.
  logic [W-1:0]      res_sel, ex_sel;
  logic              wr_res, wr_ex, bad_op, cond_sel;
  logic [COST_W-1:0] cost_sel;

  always_comb begin
    res_sel  = '0;
    ex_sel   = ex_q;
    wr_res   = 1'b0;
    wr_ex    = 1'b0;
    bad_op   = 1'b0;
    cond_sel = 1'b0;
    cost_sel = COST1;
    case (op)
      OP_ADD, OP_SUB, OP_MUL, OP_MLI, OP_ADX, OP_SBX: begin
        res_sel  = am_lo;
        ex_sel   = am_hi;
        wr_res   = 1'b1;
        wr_ex    = 1'b1;
        cost_sel = (op == OP_ADX || op == OP_SBX) ? COST3 : COST2;
      end
      OP_DIV, OP_DVI: begin
        res_sel  = (a_i == '0) ? '0 : quo_fix[DW-1:W];
        ex_sel   = (a_i == '0) ? '0 : quo_fix[W-1:0];
        wr_res   = 1'b1;
        wr_ex    = 1'b1;
        cost_sel = COST3;
      end
      OP_MOD, OP_MDI: begin
        res_sel  = (a_i == '0) ? '0 : rem_fix;
        wr_res   = 1'b1;
        cost_sel = COST3;
      end
      OP_AND, OP_BOR, OP_XOR: begin
        res_sel = sl_res;
        wr_res  = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ASR: begin
        res_sel = sl_res;
        ex_sel  = sl_ex;
        wr_res  = 1'b1;
        wr_ex   = 1'b1;
      end
      OP_IFB, OP_IFC, OP_IFE, OP_IFN, OP_IFG, OP_IFA, OP_IFL, OP_IFU: begin
        cond_sel = sl_cond;
        cost_sel = sl_cond ? COST2 : COST3;
      end
      default: bad_op = 1'b1;
    endcase
  end

  assign result_o  = res_sel;
  assign ex_new_o  = ex_sel;
  assign res_we_o  = issue_i && wr_res;
  assign ex_we_o   = issue_i && wr_ex;
  assign illegal_o = issue_i && bad_op;
  assign cond_o    = cond_sel;
  assign cost_o    = cost_sel;

  // EX register: next state, clock enable, then the flop.
  logic         ex_en;
  logic [W-1:0] ex_nxt;

  always_comb begin
    ex_en  = ex_we_o;
    ex_nxt = ex_sel;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   ex_q <= '0;
    else if (ex_en) ex_q <= ex_nxt;
  end

  assign ex_o = ex_q;

  // Assertions
  assert_ex_load_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    ex_we_o |=> ex_o == $past(ex_new_o));

  assert_ex_hold_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ex_we_o |=> $stable(ex_o));

  assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (opcode_i == OP_DIV || opcode_i == OP_DVI) && a_i == '0
      |-> result_o == '0 && ex_new_o == '0);

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    illegal_o |-> !res_we_o && !ex_we_o);

  assert_cmp_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    is_compare(opcode_i) |-> !res_we_o && !ex_we_o);

  assert_cmp_cost_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    is_compare(opcode_i) |-> cost_o == (cond_o ? COST2 : COST3));

  assert_add_pack_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    opcode_i == OP_ADD |-> {ex_new_o, result_o} == DW'(b_i) + DW'(a_i));

  assert_div_identity_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    a_mag != '0 |-> (PW'(dv_quo) * PW'(a_mag) + PW'(dv_rem)) == PW'(dv_num)
                    && dv_rem < a_mag);

endmodule

// File: tb/alu_ex_unit_tb_top.sv
module alu_ex_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [4:0]  opcode;
  logic [15:0] b, a;
  logic [15:0] result, ex_new, ex_cur;
  logic        res_we, ex_we, cond, illegal;
  logic [1:0]  cost;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow_ex;

  always #5 clk = ~clk;

  alu_ex_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .opcode_i(opcode),
    .b_i(b), .a_i(a), .result_o(result), .res_we_o(res_we),
    .ex_new_o(ex_new), .ex_we_o(ex_we), .ex_o(ex_cur), .cond_o(cond),
    .illegal_o(illegal), .cost_o(cost)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void model(input logic [4:0] op, input logic [15:0] vb,
      input logic [15:0] va, input logic [15:0] ve,
      output logic [15:0] r, output logic [15:0] e, output logic wr,
      output logic we, output logic c, output logic [1:0] cst, output logic ill);
    logic [31:0] t;
    longint q;
    int m;
    r = 16'h0; e = ve; wr = 1'b0; we = 1'b0; c = 1'b0; cst = 2'd1; ill = 1'b0;
    t = 32'h0;
    case (op)
      5'h02, 5'h03, 5'h04, 5'h05, 5'h1a, 5'h1b: begin
        case (op)
          5'h02: t = 32'(vb) + 32'(va);
          5'h03: t = 32'(vb) - 32'(va);
          5'h04: t = 32'(vb) * 32'(va);
          5'h05: t = 32'(int'($signed(vb)) * int'($signed(va)));
          5'h1a: t = 32'(vb) + 32'(va) + 32'(ve);
          default: t = 32'(vb) - 32'(va) + 32'(ve);
        endcase
        r = t[15:0]; e = t[31:16]; wr = 1; we = 1;
        cst = (op == 5'h1a || op == 5'h1b) ? 2'd3 : 2'd2;
      end
      5'h06, 5'h07: begin
        wr = 1; we = 1; cst = 2'd3;
        if (va == 0) begin r = 0; e = 0; end
        else begin
          if (op == 5'h06) t = {vb, 16'h0} / 32'(va);
          else begin
            q = (longint'($signed(vb)) * 65536) / longint'($signed(va));
            t = q[31:0];
          end
          r = t[31:16]; e = t[15:0];
        end
      end
      5'h08, 5'h09: begin
        wr = 1; cst = 2'd3;
        if (va == 0) r = 0;
        else if (op == 5'h08) r = vb % va;
        else begin m = int'($signed(vb)) % int'($signed(va)); r = m[15:0]; end
      end
      5'h0a: begin r = vb & va; wr = 1; end
      5'h0b: begin r = vb | va; wr = 1; end
      5'h0c: begin r = vb ^ va; wr = 1; end
      5'h0f: begin t = 32'(vb) << va; r = t[15:0]; e = t[31:16]; wr = 1; we = 1; end
      5'h0d: begin t = {vb, 16'h0} >> va; r = t[31:16]; e = t[15:0]; wr = 1; we = 1; end
      5'h0e: begin t = $signed({vb, 16'h0}) >>> va; r = t[31:16]; e = t[15:0]; wr = 1; we = 1; end
      5'h10: c = (vb & va) != 0;
      5'h11: c = (vb & va) == 0;
      5'h12: c = vb == va;
      5'h13: c = vb != va;
      5'h14: c = vb > va;
      5'h15: c = $signed(vb) > $signed(va);
      5'h16: c = vb < va;
      5'h17: c = $signed(vb) < $signed(va);
      default: ill = 1'b1;
    endcase
    if (op[4:3] == 2'b10) cst = c ? 2'd2 : 2'd3;
  endfunction

  // Drive one operation, check the outputs, then the EX register after the edge.
  task automatic run_op(input logic iss, input logic [4:0] op,
                        input logic [15:0] vb, input logic [15:0] va, input string tag);
    logic [15:0] r, e;
    logic wr, we, c, ill;
    logic [1:0] cst;
    @(negedge clk);
    issue = iss; opcode = op; b = vb; a = va;
    #2;
    model(op, vb, va, shadow_ex, r, e, wr, we, c, cst, ill);
    chk(tag, "res_we", res_we, iss & wr);
    chk(tag, "ex_we", ex_we, iss & we);
    chk(tag, "illegal", illegal, iss & ill);
    chk(tag, "cond", cond, c);
    chk("R9", "cost", cost, cst);
    if (wr) chk(tag, "result", result, r);
    if (we) chk(tag, "ex_new", ex_new, e);
    @(posedge clk);
    #1;
    if (iss && we) shadow_ex = e;
    chk(tag, "ex_reg", ex_cur, shadow_ex);
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; issue = 1'b0; opcode = 5'h0; b = 16'h0; a = 16'h0;
    shadow_ex = 16'h0;
    repeat (3) @(posedge clk);
    #1 chk("R1", "ex during reset", ex_cur, 16'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", "ex after release", ex_cur, 16'h0);
  endtask

  task automatic t_arith_r2();
    run_op(1, 5'h02, 16'hFFFF, 16'h0001, "R2");
    run_op(1, 5'h02, 16'h1234, 16'h0F00, "R2");
    run_op(1, 5'h03, 16'h0001, 16'h0002, "R2");
    run_op(1, 5'h04, 16'h1234, 16'h0100, "R2");
    run_op(1, 5'h05, 16'hFFFE, 16'h0003, "R2");
    run_op(1, 5'h02, 16'hFFFF, 16'hFFFF, "R2");
    run_op(1, 5'h1a, 16'hFFFF, 16'h0001, "R2");
    run_op(1, 5'h1b, 16'h0005, 16'h0009, "R2");
    run_op(1, 5'h1b, 16'h0005, 16'h0001, "R2");
  endtask

  task automatic t_shift_r3();
    run_op(1, 5'h0f, 16'h8001, 16'd4, "R3");
    run_op(1, 5'h0d, 16'h8421, 16'd4, "R3");
    run_op(1, 5'h0e, 16'h8421, 16'd4, "R3");
    run_op(1, 5'h0e, 16'h8000, 16'd40, "R3");
    run_op(1, 5'h0d, 16'hFFFF, 16'd40, "R3");
    run_op(1, 5'h0f, 16'hFFFF, 16'd32, "R3");
    run_op(1, 5'h0d, 16'h1234, 16'd16, "R3");
  endtask

  task automatic t_div_r4();
    run_op(1, 5'h06, 16'h0001, 16'h0003, "R4");
    run_op(1, 5'h06, 16'hFFFF, 16'h0001, "R4");
    run_op(1, 5'h07, 16'hFFF9, 16'h0002, "R4");
    run_op(1, 5'h07, 16'h0007, 16'hFFFE, "R4");
    run_op(1, 5'h07, 16'h8000, 16'hFFFF, "R4");
  endtask

  task automatic t_divzero_r5();
    run_op(1, 5'h02, 16'hFFFF, 16'h0002, "R5");
    run_op(1, 5'h06, 16'h1234, 16'h0000, "R5");
    run_op(1, 5'h02, 16'hFFFF, 16'h0003, "R5");
    run_op(1, 5'h07, 16'h8000, 16'h0000, "R5");
    run_op(1, 5'h02, 16'hFFFF, 16'h0004, "R5");
    run_op(1, 5'h08, 16'h1234, 16'h0000, "R5");
    run_op(1, 5'h09, 16'hF234, 16'h0000, "R5");
  endtask

  task automatic t_mod_r6();
    run_op(1, 5'h08, 16'd100, 16'd7, "R6");
    run_op(1, 5'h09, 16'hFFF9, 16'd2, "R6");
    run_op(1, 5'h09, 16'd7, 16'hFFFE, "R6");
    run_op(1, 5'h09, 16'h8000, 16'hFFFF, "R6");
  endtask

  task automatic t_logic_r7();
    run_op(1, 5'h0a, 16'hF0F0, 16'h3C3C, "R7");
    run_op(1, 5'h0b, 16'hF0F0, 16'h3C3C, "R7");
    run_op(1, 5'h0c, 16'hF0F0, 16'h3C3C, "R7");
  endtask

  task automatic t_cmp_r8();
    for (int op = 16; op < 24; op++) begin
      run_op(1, 5'(op), 16'h8000, 16'h0001, "R8");
      run_op(1, 5'(op), 16'h0001, 16'h8000, "R8");
      run_op(1, 5'(op), 16'h0F0F, 16'h0F0F, "R8");
      run_op(1, 5'(op), 16'h0F00, 16'h00F0, "R8");
    end
  endtask

  task automatic t_illegal_r10();
    logic [4:0] bad [8] = '{5'h00, 5'h01, 5'h18, 5'h19, 5'h1c, 5'h1d, 5'h1e, 5'h1f};
    run_op(1, 5'h02, 16'hFFFF, 16'h0005, "R10");
    for (int i = 0; i < 8; i++) run_op(1, bad[i], 16'hFFFF, 16'hFFFF, "R10");
  endtask

  task automatic t_idle_r11();
    run_op(0, 5'h02, 16'hFFFF, 16'h0001, "R11");
    run_op(0, 5'h06, 16'h1234, 16'h0000, "R11");
    run_op(0, 5'h1f, 16'h0000, 16'h0000, "R11");
    run_op(1, 5'h0f, 16'hABCD, 16'd8, "R11");
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_arith_r2();
    t_shift_r3();
    t_div_r4();
    t_divzero_r5();
    t_mod_r6();
    t_logic_r7();
    t_cmp_r8();
    t_illegal_r10();
    t_idle_r11();
    @(negedge clk) issue = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule